// File: doc/BRIEF.md
# External Memory Bus Controller

This block runs the external memory cycles of a small 8-bit processor. A request from the core (address, direction, write data, and a flag marking a program fetch) is turned into one bus cycle on a 20-bit address bus, a split 8-bit data bus (input, output and output enable), separate active-low read and write strobes, and a bus clock. The upper four address bits form a bank field for data accesses. Program fetches always drive that field as zero, because program space is limited to the lower 64 KB.

The block is clocked at twice the oscillator rate, so one tick is half an oscillator period. Every bus timing is therefore a whole number of ticks. A free-running phase counter of eight ticks produces the bus clock, and every bus cycle is aligned to it. The address is valid two ticks before the strobe falls. The strobe stays low for five ticks. The address is held for one tick after the strobe rises. On writes, the data output enable spans the whole strobe plus that hold tick.

A slow device can stretch the strobe by raising a wait input. That input passes through a synchronizer and is sampled once per bus-clock period. Each period in which it is seen high adds eight ticks to the strobe. When the cycle ends, the core receives a one-tick completion pulse. Read data is also returned at that point.

Top module: `extbus_ctl`

## Requirements
- R1: While `rstN` is low, and in the first tick after it is released, both strobes are high, `busDoe` and `rspDone` are low and `busClk` is high. Lowering `rstN` in the middle of a cycle forces these values at once.
- R2: `busClk` repeats every 8 ticks: high for 4 ticks, then low for 4. It is high in the two ticks before a strobe falls and in the first two strobe ticks.
- R3: A request (`reqValid` high) is accepted only in the last tick of a `busClk` period while no cycle is running. The new address appears on `busAddr` in the first tick of the next period (the tick after `busClk` rises), two ticks before the strobe falls.
- R4: Without wait states, the active strobe is low for exactly 5 consecutive ticks.
- R5: `busAddr` stays unchanged from the tick it is loaded until the next request is loaded. This includes every strobe tick and the tick after the strobe rises.
- R6: On a write, `busDoe` is high from the first strobe tick through the tick after the write strobe rises, and `busDout` equals the request's write data throughout. On reads and while idle, `busDoe` stays low.
- R7: On a read, `busDin` is captured at the end of the last tick in which the read strobe is low. It appears on `rspRdata` from the tick in which the strobe rises and stays there until the next read.
- R8: `rspDone` is high for exactly one tick per cycle: the tick after the one in which the strobe returns high.
- R9: Between the end of one strobe and the start of the next, both strobes stay high for at least 3 ticks.
- R10: When `reqFetch` is high, `busAddr[19:16]` is driven as 0 whatever `reqAddr[19:16]` holds. `reqWrite` is ignored, so the cycle uses the read strobe and leaves `busDoe` low.
- R11: `busWait` passes through a two-stage synchronizer. It is sampled once per `busClk` period; the sample that counts is the value present in the first strobe tick of that period. Each period in which it is seen high adds 8 ticks to the strobe, so N such periods give a strobe of 5 + 8N ticks.
- R12: The two strobes are never low together. A read (`reqWrite` low) or any fetch uses `busRdN`; a non-fetch write uses `busWrN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, twice the oscillator rate (one tick = half an oscillator period) |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request; held until `rspDone`, then dropped |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqFetch | input | 1 | 1 = program fetch (bank forced to 0, always a read) |
| reqAddr | input | 20 | Requested address; bits 19:16 are the bank field |
| reqWdata | input | 8 | Write data |
| rspRdata | output | 8 | Last captured read data |
| rspDone | output | 1 | One-tick completion pulse |
| busClk | output | 1 | Bus clock, one eighth of the tick rate |
| busAddr | output | 20 | External address |
| busDout | output | 8 | Data driven toward memory |
| busDoe | output | 1 | Enable for `busDout` onto the external data bus |
| busDin | input | 8 | Data returned by memory |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| busWait | input | 1 | Active-high wait request from a slow device |

## Verification
The hardest situation to reach from the ports is a strobe stretched over several `busClk` periods. In that case the synchronized wait value has to be re-sampled in the right tick of each period, and read data has to be taken only in the very last low tick. The stimulus reacts to the strobe tick by tick. It counts low ticks from the strobe's fall and holds `busWait` high until the sampling tick of the final stretched period. On `busDin` it drives the expected read value in the last low tick only and its complement in every other tick. A capture one tick early or late, or a mis-timed wait sample, therefore shows up directly in `rspRdata` or in the measured strobe width.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  // Bus cycle timing, in ticks of the block clock (half an oscillator period)
  localparam int unsigned TICKS_PER_CLK = 8;
  localparam int unsigned PH_W          = $clog2(TICKS_PER_CLK);
  localparam int unsigned PH_ACCEPT     = TICKS_PER_CLK - 1;  // last tick of a bus-clock period
  localparam int unsigned PH_FALL_CMD   = 1;                  // strobe is low from phase 2
  localparam int unsigned PH_WAIT_SMP   = 4;                  // wait latched at bus-clock fall
  localparam int unsigned PH_RISE_CMD   = 6;                  // strobe is high again from phase 7

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_SETUP,
    BUS_STROBE,
    BUS_HOLD
  } busState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic captureRd;
  } dpCmd_t;

endpackage

// File: rtl/extbus_sync.sv
module extbus_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] stage;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[0] <= 1'b0;
        else       stage[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[i] <= 1'b0;
        else       stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[DEPTH-1];

endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   reqFetch,
  input  logic   waitSync,
  output dpCmd_t cmd,
  output logic   busClk,
  output logic   busRdN,
  output logic   busWrN,
  output logic   busDoe,
  output logic   rspDone
);

  logic [PH_W-1:0] phase;
  busState_t       state;
  logic            isWrite;
  logic            waitHeld;

  // Bus clock is high in phases 0..3, low in phases 4..7
  assign busClk = ~phase[PH_W-1];

  always_comb begin
    cmd.loadReq   = (state == BUS_IDLE) && (phase == PH_W'(PH_ACCEPT)) && reqValid;
    cmd.captureRd = (state == BUS_STROBE) && (phase == PH_W'(PH_RISE_CMD))
                    && !waitHeld && !isWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      state    <= BUS_IDLE;
      isWrite  <= 1'b0;
      waitHeld <= 1'b0;
      busRdN   <= 1'b1;
      busWrN   <= 1'b1;
      busDoe   <= 1'b0;
      rspDone  <= 1'b0;
    end else begin
      phase   <= phase + PH_W'(1);
      rspDone <= 1'b0;
      unique case (state)
        BUS_IDLE: begin
          if (cmd.loadReq) begin
            state   <= BUS_SETUP;
            isWrite <= reqWrite & ~reqFetch;
          end
        end
        BUS_SETUP: begin
          if (phase == PH_W'(PH_FALL_CMD)) begin
            state  <= BUS_STROBE;
            busRdN <= isWrite;
            busWrN <= ~isWrite;
            busDoe <= isWrite;
          end
        end
        BUS_STROBE: begin
          if (phase == PH_W'(PH_WAIT_SMP)) waitHeld <= waitSync;
          if ((phase == PH_W'(PH_RISE_CMD)) && !waitHeld) begin
            state  <= BUS_HOLD;
            busRdN <= 1'b1;
            busWrN <= 1'b1;
          end
        end
        BUS_HOLD: begin
          state   <= BUS_IDLE;
          busDoe  <= 1'b0;
          rspDone <= 1'b1;
        end
        default: state <= BUS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath
  import extbus_pkg::*;
#(
  parameter int unsigned LOW_W  = 16,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCmd_t                  cmd,
  input  logic [LOW_W+BANK_W-1:0] reqAddr,
  input  logic                    reqFetch,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [DATA_W-1:0]       busDin,
  output logic [LOW_W+BANK_W-1:0] busAddr,
  output logic [DATA_W-1:0]       busDout,
  output logic [DATA_W-1:0]       rspRdata
);

  localparam int unsigned ADDR_W = LOW_W + BANK_W;

  logic [BANK_W-1:0] bankSel;

  // Program fetches live in the lowest bank
  assign bankSel = reqFetch ? '0 : reqAddr[ADDR_W-1 -: BANK_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= '0;
      busDout  <= '0;
      rspRdata <= '0;
    end else begin
      if (cmd.loadReq) begin
        busAddr <= {bankSel, reqAddr[LOW_W-1:0]};
        busDout <= reqWdata;
      end
      if (cmd.captureRd) rspRdata <= busDin;
    end
  end

endmodule

// File: rtl/extbus_ctl.sv
module extbus_ctl
  import extbus_pkg::*;
#(
  parameter int unsigned LOW_W      = 16,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic                    reqFetch,
  input  logic [LOW_W+BANK_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic [DATA_W-1:0]       rspRdata,
  output logic                    rspDone,
  output logic                    busClk,
  output logic [LOW_W+BANK_W-1:0] busAddr,
  output logic [DATA_W-1:0]       busDout,
  output logic                    busDoe,
  input  logic [DATA_W-1:0]       busDin,
  output logic                    busRdN,
  output logic                    busWrN,
  input  logic                    busWait
);

  dpCmd_t cmd;
  logic   waitSync;

  extbus_sync #(.DEPTH(SYNC_DEPTH)) u_waitSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (busWait),
    .dout (waitSync)
  );

  extbus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqFetch (reqFetch),
    .waitSync (waitSync),
    .cmd      (cmd),
    .busClk   (busClk),
    .busRdN   (busRdN),
    .busWrN   (busWrN),
    .busDoe   (busDoe),
    .rspDone  (rspDone)
  );

  extbus_datapath #(.LOW_W(LOW_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .reqAddr  (reqAddr),
    .reqFetch (reqFetch),
    .reqWdata (reqWdata),
    .busDin   (busDin),
    .busAddr  (busAddr),
    .busDout  (busDout),
    .rspRdata (rspRdata)
  );

endmodule

// File: rtl/extbus_ctl_chk.sv
module extbus_ctl_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busClk,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdN,
  input logic              busWrN,
  input logic              busDoe,
  input logic              rspDone
);

  logic anyLow;
  assign anyLow = !busRdN || !busWrN;

  AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busClk) |-> $past(busClk, 2) && $past(busClk, 3) && $past(busClk, 4)); // R2
  AST_CLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busClk) |-> !$past(busClk, 2) && !$past(busClk, 3) && !$past(busClk, 4)); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!busRdN && !busWrN)); // R12
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    busDoe |-> (!busWrN || $past(!busWrN))); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(anyLow) |-> $stable(busAddr)); // R5
  AST_RECOVERY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyLow) |-> !$past(anyLow, 2) && !$past(anyLow, 3)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R8
  AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> !$past(anyLow) && $past(anyLow, 2)); // R8

endmodule

bind extbus_ctl extbus_ctl_chk #(.ADDR_W(LOW_W + BANK_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busClk  (busClk),
  .busAddr (busAddr),
  .busRdN  (busRdN),
  .busWrN  (busWrN),
  .busDoe  (busDoe),
  .rspDone (rspDone)
);

// File: tb/extbus_ctl_tb.sv
module extbus_ctl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqFetch = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  rspRdata;
  logic        rspDone, busClk, busDoe, busRdN, busWrN;
  logic [19:0] busAddr;
  logic [7:0]  busDout;
  logic [7:0]  busDin = '0;
  logic        busWait = 1'b0;

  int nChecks = 0;
  int nFail   = 0;
  int highRun = 100;

  always #2 clk = ~clk;

  extbus_ctl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqFetch(reqFetch), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspRdata(rspRdata), .rspDone(rspDone), .busClk(busClk), .busAddr(busAddr),
    .busDout(busDout), .busDoe(busDoe), .busDin(busDin), .busRdN(busRdN),
    .busWrN(busWrN), .busWait(busWait)
  );

  // {write, fetch, waits[1:0], addr[19:0], data[7:0]}
  localparam int NVEC = 7;
  localparam logic [31:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 2'd0, 20'h3_1234, 8'hA5},
    {1'b1, 1'b0, 2'd0, 20'h7_00FF, 8'h3C},
    {1'b1, 1'b0, 2'd1, 20'hA_5A5A, 8'hC3},
    {1'b0, 1'b0, 2'd2, 20'hF_FFFF, 8'h00},
    {1'b1, 1'b1, 2'd0, 20'hC_8001, 8'h77},
    {1'b0, 1'b1, 2'd1, 20'h9_0010, 8'h5E},
    {1'b0, 1'b0, 2'd3, 20'h0_0000, 8'hFF}
  };

  logic [19:0] aLog [160];
  logic [7:0]  dLog [160];
  logic [7:0]  qLog [160];
  logic        cLog [160];
  logic        rLog [160];
  logic        wLog [160];
  logic        oLog [160];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runAccess(input bit wr, input bit fe, input int nw,
                           input logic [19:0] ad, input logic [7:0] dt);
    int low, tFall, tRise, tDone, nDone, gap, eLen;
    bit anyLow, ok;
    logic [19:0] expAddr;
    low = 0; tFall = -1; tRise = -1; tDone = -1; nDone = 0; gap = 0;
    eLen = 5 + 8 * nw;
    expAddr = fe ? {4'h0, ad[15:0]} : ad;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqFetch = fe; reqAddr = ad; reqWdata = dt;
    for (int t = 0; t < 150; t++) begin
      if (t > 0) @(negedge clk);
      aLog[t] = busAddr; dLog[t] = busDout; qLog[t] = rspRdata;
      cLog[t] = busClk; rLog[t] = busRdN; wLog[t] = busWrN; oLog[t] = busDoe;
      anyLow = !busRdN || !busWrN;
      if (anyLow) begin
        if (tFall < 0) begin tFall = t; gap = highRun; end
        low++;
        highRun = 0;
      end else begin
        highRun++;
        if (tFall >= 0 && tRise < 0) tRise = t;
      end
      if (rspDone) begin
        nDone++;
        if (tDone < 0) tDone = t;
        reqValid = 1'b0;
      end
      busWait = (nw > 0) && (tRise < 0) && (low < 1 + 8 * nw);
      busDin  = (anyLow && low == eLen) ? dt : ~dt;
      if (tDone >= 0 && t >= tDone + 3) break;
    end
    reqValid = 1'b0; busWait = 1'b0;
    if (tFall < 3 || tRise < 0 || tRise + 1 >= 150) begin
      chk(1'b0, "R4 strobe not seen", 32'(tFall), 32'(tRise));
      return;
    end
    chk(tRise - tFall == eLen, nw > 0 ? "R11 stretched width" : "R4 strobe width",
        32'(tRise - tFall), 32'(eLen));
    if (wr && !fe) chk(!wLog[tFall] && rLog[tFall], "R12 write strobe", {wLog[tFall], rLog[tFall]}, 32'b01);
    else chk(!rLog[tFall] && wLog[tFall], fe ? "R10 fetch uses read" : "R12 read strobe",
             {wLog[tFall], rLog[tFall]}, 32'b10);
    chk(aLog[tFall-2] == expAddr && cLog[tFall-2] && !cLog[tFall-3], "R3 address timing",
        32'(aLog[tFall-2]), 32'(expAddr));
    if (fe) chk(busAddr[19:16] == 4'h0, "R10 fetch bank", 32'(busAddr[19:16]), 32'h0);
    ok = 1'b1;
    for (int t = tFall - 2; t <= tRise; t++) if (aLog[t] != expAddr) ok = 1'b0;
    chk(ok, "R5 address held", 32'(aLog[tRise]), 32'(expAddr));
    ok = 1'b1;
    for (int t = 0; t < 4; t++) begin
      if (!cLog[tFall - 2 + t]) ok = 1'b0;
      if (cLog[tFall + 2 + t]) ok = 1'b0;
    end
    chk(ok, "R2 bus clock shape", 32'(cLog[tFall + 2]), 32'h0);
    if (wr && !fe) begin
      ok = !oLog[tFall-1] && !oLog[tRise+1];
      for (int t = tFall; t <= tRise; t++) if (!oLog[t] || dLog[t] != dt) ok = 1'b0;
      chk(ok, "R6 write enable window", 32'(dLog[tFall]), 32'(dt));
    end else begin
      ok = 1'b1;
      for (int t = 0; t <= tDone; t++) if (oLog[t]) ok = 1'b0;
      chk(ok, fe ? "R10 fetch ignores write" : "R6 no enable on read", 32'(ok), 32'h1);
      chk(qLog[tRise] == dt, "R7 read capture", 32'(qLog[tRise]), 32'(dt));
    end
    chk(nDone == 1 && tDone == tRise + 1, "R8 done pulse", 32'(tDone), 32'(tRise + 1));
    chk(gap >= 3, "R9 recovery", 32'(gap), 32'd3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busRdN && busWrN && !busDoe && !rspDone && busClk, "R1 reset state",
        {busRdN, busWrN, busDoe, rspDone, busClk}, 32'b11001);
    rstN = 1'b1;
    @(negedge clk);
    chk(busRdN && busWrN && !busDoe && busClk, "R1 first tick after reset",
        {busRdN, busWrN, busDoe, busClk}, 32'b1101);

    // Table walk; consecutive entries also exercise the tightest spacing (R9)
    for (int i = 0; i < NVEC; i++)
      runAccess(VECS[i][31], VECS[i][30], int'(VECS[i][29:28]), VECS[i][27:8], VECS[i][7:0]);

    // Back-to-back reads with no idle gap between requests (R9)
    runAccess(1'b0, 1'b0, 0, 20'h1_0001, 8'h11);
    runAccess(1'b0, 1'b0, 0, 20'h1_0002, 8'h22);

    // Read value persists until the next read (R7)
    runAccess(1'b1, 1'b0, 0, 20'h2_2222, 8'h99);
    chk(rspRdata == 8'h22, "R7 read data held over write", 32'(rspRdata), 32'h22);

    // Reset in the middle of a write strobe (R1)
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqFetch = 1'b0; reqAddr = 20'h4_4444; reqWdata = 8'h44;
    for (int t = 0; t < 40 && busWrN; t++) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!busWrN && busDoe, "R6 write in flight", {busWrN, busDoe}, 32'b01);
    rstN = 1'b0;
    #1;
    chk(busRdN && busWrN && !busDoe && !rspDone && busClk, "R1 reset aborts cycle",
        {busRdN, busWrN, busDoe, rspDone, busClk}, 32'b11001);
    @(negedge clk);
    rstN = 1'b1;
    highRun = 100;
    runAccess(1'b0, 1'b0, 1, 20'h5_0505, 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule